// File: doc/BRIEF.md
# Protected Control Register Sequencer

This block holds a supervisor's control byte and guards it with a byte-level write and read interface. A write transaction is framed by a start pulse and a stop pulse with data bytes in between. The block answers every data byte with an ack or a nack one cycle later. A read request returns the register image on the next cycle.

Two volatile latches protect the persistent fields: the watchdog period select, the power-up delay select and the block-protect flag. The enable latch is set by writing 02h. Writing 06h then sets both latches. A third write, which must have bit 2 clear, commits the field values. The commit takes effect on the stop pulse and starts a busy window that stands in for the nonvolatile write time. The new field values reach the outputs when the window ends. Only one data byte is allowed per transaction. A second byte is nacked and cancels the whole transaction.

Top module: `ctlreg_seq`

## Requirements
- R1: After reset both latches are clear, the watchdog select is 11, the power-up select is 01, block protect is 0 and busy is low. A read returns 61h. The image layout is bit7 power-up high bit, bit6..5 watchdog select, bit4 block protect, bit3 zero, bit2 register-enable latch, bit1 enable latch, bit0 power-up low bit.
- R2: Each data byte is answered by ack_valid on the cycle after it is presented, with ack=1 for accept and ack=0 for refuse.
- R3: Byte 02h is acked even while the enable latch is clear. At stop it sets the enable latch, so a read then returns 63h.
- R4: With the enable latch set, byte 06h sets both latches at stop. The register-enable latch is never set while the enable latch is clear.
- R5: While the enable latch is clear, every byte other than 02h is nacked and has no effect.
- R6: With the register-enable latch set, a byte with bit 2 = 0 clears that latch at stop and raises busy for exactly BUSY_TICKS cycles. It loads the fields from the byte, and the new values appear on the outputs only when busy falls. The sequence 02h, 06h, 02h leaves all fields at zero.
- R7: With the register-enable latch set, a byte with bit 2 = 1 leaves the fields unchanged, starts no busy window, and keeps both latches set.
- R8: A second data byte in one transaction is nacked, and nothing is applied at that transaction's stop.
- R9: Data bytes presented while busy is high are nacked and have no effect.
- R10: With the register-enable latch clear and the enable latch set, byte 00h clears the enable latch at stop.
- R11: A read request returns exactly one image byte on the next cycle. A read made between a data byte and its stop does not disturb the pending write.
- R12: With the register-enable latch clear and the enable latch set, bytes other than 00h, 02h and 06h are acked and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Start marker of a write transaction |
| txn_stop | input | 1 | Stop marker; applies the pending byte |
| wr_valid | input | 1 | Data byte strobe |
| wr_byte | input | 8 | Data byte |
| rd_req | input | 1 | Read request |
| ack_valid | output | 1 | Response strobe for a data byte |
| ack | output | 1 | 1 = accepted, 0 = refused |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 8 | Register image |
| wdt_sel | output | 2 | Watchdog period select |
| pud_sel | output | 2 | Power-up delay select |
| blk_prot | output | 1 | Block protect flag |
| busy | output | 1 | Commit window active |

## Verification
The assertions assume that the start, stop, data-byte and read strobes are never raised in the same cycle. They also assume that a stop never arrives without a start before it. The bench drives each strobe alone for one cycle at a falling clock edge, with at least one idle cycle between strobes, so these assumptions always hold. The busy-window checks also assume that no commit can arrive while busy is high. The stimulus meets this by waiting for busy to fall before the next enabling sequence. Any byte it sends during the window is only meant to be refused.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_CLR_EN  = 8'h00;
    localparam logic [BYTE_W-1:0] CODE_SET_EN  = 8'h02;
    localparam logic [BYTE_W-1:0] CODE_SET_ALL = 8'h06;

    localparam int POS_PU_HI = 7;
    localparam int POS_WD_HI = 6;
    localparam int POS_WD_LO = 5;
    localparam int POS_BP    = 4;
    localparam int POS_REN   = 2;
    localparam int POS_EN    = 1;
    localparam int POS_PU_LO = 0;

    typedef struct packed {
        logic [1:0] wd;
        logic [1:0] pu;
        logic       bp;
    } fields_t;

    typedef struct packed {
        logic              in_frame;
        logic              seen;
        logic              pend;
        logic [BYTE_W-1:0] held;
        logic              ack_valid;
        logic              ack;
    } frame_t;

    typedef struct packed {
        logic              en;
        logic              ren;
        fields_t           live;
        fields_t           staged;
        logic              rd_valid;
        logic [BYTE_W-1:0] rd_data;
    } ctl_t;

    function automatic logic [BYTE_W-1:0] make_image(fields_t f, logic ren, logic en);
        logic [BYTE_W-1:0] v;
        v            = '0;
        v[POS_PU_HI] = f.pu[1];
        v[POS_WD_HI] = f.wd[1];
        v[POS_WD_LO] = f.wd[0];
        v[POS_BP]    = f.bp;
        v[POS_REN]   = ren;
        v[POS_EN]    = en;
        v[POS_PU_LO] = f.pu[0];
        return v;
    endfunction

    function automatic fields_t take_fields(logic [BYTE_W-1:0] b);
        fields_t f;
        f.wd = {b[POS_WD_HI], b[POS_WD_LO]};
        f.pu = {b[POS_PU_HI], b[POS_PU_LO]};
        f.bp = b[POS_BP];
        return f;
    endfunction
endpackage

// File: rtl/ctlreg_busy.sv
module ctlreg_busy #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(TICKS);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (kick)             cnt_d = LOAD;
        else if (cnt_q != '0) cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == ONE);

    assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
    assert_no_rekick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !kick);
    assert_window_counts_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !kick) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/ctlreg_frame.sv
module ctlreg_frame
    import ctlreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              accept_ok,
    output logic              ack_valid,
    output logic              ack,
    output logic              commit,
    output logic [BYTE_W-1:0] commit_byte
);
    frame_t fr_d, fr_q;

    always_comb begin
        fr_d           = fr_q;
        fr_d.ack_valid = 1'b0;
        fr_d.ack       = 1'b0;
        if (start) begin
            fr_d.in_frame = 1'b1;
            fr_d.seen     = 1'b0;
            fr_d.pend     = 1'b0;
        end else if (stop) begin
            fr_d.in_frame = 1'b0;
            fr_d.seen     = 1'b0;
            fr_d.pend     = 1'b0;
        end else if (wr_valid) begin
            fr_d.ack_valid = 1'b1;
            if (fr_q.in_frame && !fr_q.seen) begin
                fr_d.ack  = accept_ok;
                fr_d.pend = accept_ok;
                fr_d.held = wr_byte;
                fr_d.seen = 1'b1;
            end else begin
                fr_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign ack_valid   = fr_q.ack_valid;
    assign ack         = fr_q.ack;
    assign commit      = stop && !start && fr_q.in_frame && fr_q.pend;
    assign commit_byte = fr_q.held;

    assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> ack_valid);
    assert_no_stray_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !ack_valid);
    assert_second_byte_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !start && !stop && fr_q.seen) |=> (ack_valid && !ack));
    assert_no_commit_after_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && fr_q.seen) |=> !commit);
endmodule

// File: rtl/ctlreg_seq.sv
module ctlreg_seq
    import ctlreg_pkg::*;
#(
    parameter int         BUSY_TICKS = 16,
    parameter logic [1:0] WD_RESET   = 2'b11,
    parameter logic [1:0] PU_RESET   = 2'b01,
    parameter logic       BP_RESET   = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_start,
    input  logic       txn_stop,
    input  logic       wr_valid,
    input  logic [7:0] wr_byte,
    input  logic       rd_req,
    output logic       ack_valid,
    output logic       ack,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic [1:0] wdt_sel,
    output logic [1:0] pud_sel,
    output logic       blk_prot,
    output logic       busy
);
    localparam fields_t FIELDS_RESET = '{wd: WD_RESET, pu: PU_RESET, bp: BP_RESET};

    ctl_t              st_d, st_q;
    logic              accept_ok;
    logic              commit;
    logic [BYTE_W-1:0] commit_byte;
    logic              kick;
    logic              done;

    assign accept_ok = !busy && (st_q.en || (wr_byte == CODE_SET_EN));

    ctlreg_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (txn_start),
        .stop       (txn_stop),
        .wr_valid   (wr_valid),
        .wr_byte    (wr_byte),
        .accept_ok  (accept_ok),
        .ack_valid  (ack_valid),
        .ack        (ack),
        .commit     (commit),
        .commit_byte(commit_byte)
    );

    ctlreg_busy #(.TICKS(BUSY_TICKS)) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .kick (kick),
        .busy (busy),
        .done (done)
    );

    always_comb begin
        st_d          = st_q;
        kick          = 1'b0;
        st_d.rd_valid = rd_req;
        if (rd_req) st_d.rd_data = make_image(st_q.live, st_q.ren, st_q.en);

        if (commit) begin
            if (st_q.ren) begin
                if (!commit_byte[POS_REN]) begin
                    st_d.staged = take_fields(commit_byte);
                    st_d.ren    = 1'b0;
                    kick        = 1'b1;
                end
            end else begin
                case (commit_byte)
                    CODE_SET_EN:  st_d.en = 1'b1;
                    CODE_SET_ALL: begin
                        st_d.en  = 1'b1;
                        st_d.ren = 1'b1;
                    end
                    CODE_CLR_EN:  st_d.en = 1'b0;
                    default:      ;
                endcase
            end
        end

        if (done) st_d.live = st_q.staged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.live     <= FIELDS_RESET;
            st_q.staged   <= FIELDS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;
    assign wdt_sel  = st_q.live.wd;
    assign pud_sel  = st_q.live.pu;
    assign blk_prot = st_q.live.bp;

    assert_ren_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ren |-> st_q.en);
    assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_valid) |=> (ack_valid && !ack));
    assert_fields_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable({wdt_sel, pud_sel, blk_prot}));
    assert_read_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    assert_locked_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !st_q.en && wr_byte != CODE_SET_EN) |=> !ack);
endmodule

// File: tb/tb_ctlreg_seq.sv
module tb_ctlreg_seq;
    localparam int TICKS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0, txn_stop = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       ack_valid, ack, rd_valid, blk_prot, busy;
    logic [7:0] rd_data;
    logic [1:0] wdt_sel, pud_sel;

    int checks = 0;
    int errors = 0;
    int busy_run = 0;
    int last_run = 0;

    typedef struct {
        bit         is_rd;
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    ctlreg_seq #(.BUSY_TICKS(TICKS)) dut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req),
        .ack_valid(ack_valid), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .wdt_sel(wdt_sel), .pud_sel(pud_sel), .blk_prot(blk_prot), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard items as responses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_run++;
            else if (busy_run != 0) begin
                last_run = busy_run;
                busy_run = 0;
            end
            if (ack_valid || rd_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "unexpected response", int'(rd_data), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.is_rd)
                        check(rd_valid && !ack_valid && rd_data == e.val, e.tag,
                              int'(rd_data), int'(e.val));
                    else
                        check(ack_valid && !rd_valid && {7'b0, ack} == e.val, e.tag,
                              int'(ack), int'(e.val));
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) txn_start = 1'b1;
        @(negedge clk) txn_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) txn_stop = 1'b1;
        @(negedge clk) txn_stop = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_byte  = b;
        sb.push_back('{is_rd: 1'b0, val: {7'b0, exp_ack}, tag: tag});
        @(negedge clk);
        wr_valid = 1'b0;
        check(ack_valid == 1'b1, "R2 ack timing", int'(ack_valid), 1);
    endtask

    task automatic write1(input logic [7:0] b, input bit exp_ack, input string tag);
        pulse_start();
        send_byte(b, exp_ack, tag);
        pulse_stop();
    endtask

    task automatic read_exp(input logic [7:0] v, input string tag);
        @(negedge clk);
        rd_req = 1'b1;
        sb.push_back('{is_rd: 1'b1, val: v, tag: tag});
        @(negedge clk) rd_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(wdt_sel == 2'b11, "R1 wdt_sel", int'(wdt_sel), 3);
        check(pud_sel == 2'b01, "R1 pud_sel", int'(pud_sel), 1);
        check(blk_prot == 1'b0 && busy == 1'b0, "R1 prot/busy", int'({blk_prot, busy}), 0);
        read_exp(8'h61, "R1 reset image");

        // R5 locked: 06h refused
        write1(8'h06, 1'b0, "R5 locked nack");
        read_exp(8'h61, "R5 no effect");

        // R3 enable latch
        write1(8'h02, 1'b1, "R3 set enable ack");
        read_exp(8'h63, "R3 image");

        // R8 second byte aborts
        pulse_start();
        send_byte(8'h06, 1'b1, "R8 first byte ack");
        send_byte(8'h06, 1'b0, "R8 second byte nack");
        pulse_stop();
        read_exp(8'h63, "R8 nothing applied");

        // R12 other byte ignored
        write1(8'h55, 1'b1, "R12 ack");
        read_exp(8'h63, "R12 no change");

        // R4 both latches
        write1(8'h06, 1'b1, "R4 ack");
        read_exp(8'h67, "R4 image");

        // R7 bit2 set keeps fields
        write1(8'h06, 1'b1, "R7 ack");
        read_exp(8'h67, "R7 image");
        check(busy == 1'b0 && wdt_sel == 2'b11, "R7 no window", int'({busy, wdt_sel}), 3);

        // R6 commit with read in the middle (R11)
        pulse_start();
        send_byte(8'hB1, 1'b1, "R6 commit ack");
        read_exp(8'h67, "R11 read mid-frame");
        pulse_stop();
        check(busy == 1'b1 && wdt_sel == 2'b11 && pud_sel == 2'b01,
              "R6 old fields while busy", int'({busy, wdt_sel, pud_sel}), 'h1d);
        read_exp(8'h63, "R6 image during window");
        write1(8'h02, 1'b0, "R9 busy nack");
        wait_idle();
        check(last_run == TICKS, "R6 window length", last_run, TICKS);
        check(wdt_sel == 2'b01 && pud_sel == 2'b11 && blk_prot == 1'b1,
              "R6 new fields", int'({wdt_sel, pud_sel, blk_prot}), 'h0f);
        read_exp(8'hB3, "R6 image after window");

        // R6 sequence 02h,06h,02h clears fields
        write1(8'h02, 1'b1, "R6 seq step1");
        write1(8'h06, 1'b1, "R6 seq step2");
        write1(8'h02, 1'b1, "R6 seq step3");
        wait_idle();
        check(wdt_sel == 2'b00 && pud_sel == 2'b00 && blk_prot == 1'b0,
              "R6 cleared fields", int'({wdt_sel, pud_sel, blk_prot}), 0);
        read_exp(8'h02, "R6 cleared image");

        // R10 clear enable
        write1(8'h00, 1'b1, "R10 ack");
        read_exp(8'h00, "R10 image");
        write1(8'h06, 1'b0, "R5 relocked nack");
        read_exp(8'h00, "R5 relocked image");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R11 scoreboard drained", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule